// File: doc/BRIEF.md
# Six-Channel Gate Control with Fault Qualification and Latching

This block is the per-channel decision logic of a six-channel low-side gate pre-driver. Each channel has two raw fault detector flags: an open-load flag and a flag that gathers every other channel fault. The block qualifies them with the channel's configuration bits, latches the faults that survive, and drives one gate-enable output per channel. A channel's gate is driven high only when the external active-low driver enable pin is high, the channel's gate-select bit is set, and the channel holds no fault.

Fault qualification works at two levels. A per-channel mask bit hides every fault on that channel. A global open-load mask hides open-load faults, but only on channels whose pull-down current has been turned off by that channel's no-pull-down bit. The block also drives a pull-down-enable output per channel, which is the inverse of the no-pull-down bit. A latched fault is kept until a one-cycle clear strobe arrives, which a valid serial write produces, or until the block's reset. Taking the driver enable pin low forces every gate low but leaves the latched faults and all register inputs as they are.

Top module: `lsd_fault_gate`

## Requirements
- R1: While `rst_n` is low, and on the first edge after it is released, `gate_out` and both fault vectors read 0 and `pd_en` reads all ones.
- R2: One clock edge after `gate_sel[x]`=1 and `drv_rst_n`=1 are sampled, with no fault latched or arriving on channel x, `gate_out[x]` reads 1. A 0 in `gate_sel[x]` gives `gate_out[x]`=0 on the next edge.
- R3: One edge after `drv_rst_n` is sampled low, every `gate_out` bit reads 0. The latched fault vectors are unchanged, and the gates come back on the first edge after the pin returns high, with no clear needed.
- R4: A `raw_other[x]`=1 sampled on a channel whose `chan_mask[x]`=0 sets `flt_other[x]` on that edge and drives `gate_out[x]` to 0 on the same edge.
- R5: A `raw_open[x]`=1 sampled with `chan_mask[x]`=0, and not suppressed under R6, sets `flt_open[x]` and drives `gate_out[x]` to 0 on the same edge.
- R6: An open-load fault on channel x is ignored when `ol_mask`=1 and `no_pd[x]`=1 are both sampled. If either of them is 0, the fault latches.
- R7: With `chan_mask[x]`=1, neither raw flag of channel x latches, and the gate of channel x keeps following `gate_sel[x]` and `drv_rst_n`.
- R8: A latched fault stays set after its raw flag drops, until `flt_clr` is sampled high. On that edge both fault vectors go to 0. The clear has priority over a fault sampled in the same cycle; a fault that is still present latches again on the following edge.
- R9: `pd_en[x]` reads the inverse of `no_pd[x]` one edge after it is sampled.
- R10: A fault on one channel has no effect on the fault flags or the gate of any other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low block reset (power-on) |
| drv_rst_n | input | 1 | Active-low driver enable pin; low forces all gates low |
| gate_sel | input | NCH | Gate-select register field, bit x commands channel x |
| no_pd | input | NCH | Per-channel no-pull-down configuration bit |
| chan_mask | input | NCH | Per-channel mask that hides all faults of the channel |
| ol_mask | input | 1 | Global open-load mask, effective only on channels with no_pd set |
| raw_open | input | NCH | Raw open-load detector flags |
| raw_other | input | NCH | Raw flags for all other channel faults |
| flt_clr | input | 1 | One-cycle strobe from a valid serial write; clears latched faults |
| gate_out | output | NCH | Registered gate-enable outputs |
| pd_en | output | NCH | Registered pull-down current enable per channel |
| flt_open | output | NCH | Latched open-load faults |
| flt_other | output | NCH | Latched other faults |

## Verification
Every cycle, the assertions check that no gate is ever high on a channel that holds a latched fault. They also check that a low driver enable pin gives all-low gates on the next edge, that a clear empties both fault vectors, that latched bits only fall on a clear, that masked faults never set a latch, and that the pull-down enables follow the configuration. The bench's scenarios show the rest. Gates must actually turn on under the right conditions. The four combinations of global open-load mask and no-pull-down bit are driven one by one. A clear that collides with a live fault must relatch on the next edge. A fault on one channel must leave its neighbours untouched.

// File: rtl/lsd_pkg.sv
package lsd_pkg;

    // Registered state of one channel
    typedef struct packed {
        logic open_flt;
        logic other_flt;
        logic gate;
        logic pd_en;
    } chan_state_t;

    // Qualified fault requests of one channel for the current cycle
    typedef struct packed {
        logic open_req;
        logic other_req;
    } chan_req_t;

    localparam chan_state_t CHAN_RESET = '{
        open_flt:  1'b0,
        other_flt: 1'b0,
        gate:      1'b0,
        pd_en:     1'b1
    };

endpackage

// File: rtl/lsd_fault_qual.sv
module lsd_fault_qual
    import lsd_pkg::*;
(
    input  logic      raw_open,
    input  logic      raw_other,
    input  logic      chan_mask,
    input  logic      no_pd,
    input  logic      ol_mask,
    output chan_req_t req
);

    logic open_hidden;

    always_comb begin
        // Open-load is hidden globally only where the pull-down is switched off
        open_hidden   = ol_mask & no_pd;
        req.open_req  = raw_open & ~chan_mask & ~open_hidden;
        req.other_req = raw_other & ~chan_mask;
    end

endmodule

// File: rtl/lsd_chan_reg.sv
module lsd_chan_reg
    import lsd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        drv_on,
    input  logic        gate_cmd,
    input  logic        no_pd,
    input  logic        flt_clr,
    input  chan_req_t   req,
    output chan_state_t state
);

    chan_state_t st_d;
    chan_state_t st_q;

    always_comb begin
        st_d = st_q;
        if (flt_clr) begin
            // Clear wins over a request of the same cycle
            st_d.open_flt  = 1'b0;
            st_d.other_flt = 1'b0;
        end else begin
            st_d.open_flt  = st_q.open_flt | req.open_req;
            st_d.other_flt = st_q.other_flt | req.other_req;
        end
        st_d.gate  = drv_on & gate_cmd & ~(st_d.open_flt | st_d.other_flt);
        st_d.pd_en = ~no_pd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= CHAN_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign state = st_q;

endmodule

// File: rtl/lsd_fault_gate.sv
module lsd_fault_gate
    import lsd_pkg::*;
#(
    parameter int NCH = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           drv_rst_n,
    input  logic [NCH-1:0] gate_sel,
    input  logic [NCH-1:0] no_pd,
    input  logic [NCH-1:0] chan_mask,
    input  logic           ol_mask,
    input  logic [NCH-1:0] raw_open,
    input  logic [NCH-1:0] raw_other,
    input  logic           flt_clr,
    output logic [NCH-1:0] gate_out,
    output logic [NCH-1:0] pd_en,
    output logic [NCH-1:0] flt_open,
    output logic [NCH-1:0] flt_other
);

    chan_req_t   req_w [NCH];
    chan_state_t st_w  [NCH];

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        lsd_fault_qual u_qual (
            .raw_open  (raw_open[ch]),
            .raw_other (raw_other[ch]),
            .chan_mask (chan_mask[ch]),
            .no_pd     (no_pd[ch]),
            .ol_mask   (ol_mask),
            .req       (req_w[ch])
        );

        lsd_chan_reg u_reg (
            .clk      (clk),
            .rst_n    (rst_n),
            .drv_on   (drv_rst_n),
            .gate_cmd (gate_sel[ch]),
            .no_pd    (no_pd[ch]),
            .flt_clr  (flt_clr),
            .req      (req_w[ch]),
            .state    (st_w[ch])
        );

        assign gate_out[ch]  = st_w[ch].gate;
        assign pd_en[ch]     = st_w[ch].pd_en;
        assign flt_open[ch]  = st_w[ch].open_flt;
        assign flt_other[ch] = st_w[ch].other_flt;
    end

endmodule

// File: rtl/lsd_fault_gate_chk.sv
module lsd_fault_gate_chk #(
    parameter int NCH = 6
) (
    input logic           clk,
    input logic           rst_n,
    input logic           drv_rst_n,
    input logic [NCH-1:0] gate_sel,
    input logic [NCH-1:0] no_pd,
    input logic [NCH-1:0] chan_mask,
    input logic           ol_mask,
    input logic [NCH-1:0] raw_open,
    input logic [NCH-1:0] raw_other,
    input logic           flt_clr,
    input logic [NCH-1:0] gate_out,
    input logic [NCH-1:0] pd_en,
    input logic [NCH-1:0] flt_open,
    input logic [NCH-1:0] flt_other
);

    // R4 R5: a gate is never on while its channel holds a fault
    p_no_gate_on_fault_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_out & (flt_open | flt_other)) == '0);

    // R2: a gate can only be on if it was selected
    p_gate_needs_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (gate_out & ~$past(gate_sel)) == '0);

    // R3: low driver enable pin turns all gates off
    p_pin_low_gates_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !drv_rst_n |=> gate_out == '0);

    // R8: clear empties both fault vectors
    p_clear_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flt_clr |=> (flt_open == '0 && flt_other == '0));

    // R8: latched bits never fall without a clear
    p_latch_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !flt_clr |=> ((($past(flt_open) & ~flt_open) == '0) &&
                      (($past(flt_other) & ~flt_other) == '0)));

    // R7: a masked channel never gains a fault bit
    p_mask_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((((flt_open & ~$past(flt_open)) | (flt_other & ~$past(flt_other)))
                   & $past(chan_mask)) == '0));

    // R6: open-load hidden where global mask and no-pull-down meet
    p_olm_hides_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flt_open & ~$past(flt_open) & $past(no_pd & {NCH{ol_mask}})) == '0));

    // R5: raw open flag needed for a new open-load bit
    p_open_needs_raw_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flt_open & ~$past(flt_open) & ~$past(raw_open)) == '0));

    // R4: raw other flag needed for a new other-fault bit
    p_other_needs_raw_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flt_other & ~$past(flt_other) & ~$past(raw_other)) == '0));

    // R9: pull-down enable follows the configuration
    p_pd_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> pd_en == ~$past(no_pd));

endmodule

bind lsd_fault_gate lsd_fault_gate_chk #(.NCH(NCH)) u_chk (.*);

// File: tb/lsd_fault_gate_tb.sv
module lsd_fault_gate_tb_top;

    localparam int CLK_P = 10;
    localparam int NCH   = 6;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           drv_rst_n = 1'b1;
    logic [NCH-1:0] gate_sel = '0;
    logic [NCH-1:0] no_pd = '0;
    logic [NCH-1:0] chan_mask = '0;
    logic           ol_mask = 1'b0;
    logic [NCH-1:0] raw_open = '0;
    logic [NCH-1:0] raw_other = '0;
    logic           flt_clr = 1'b0;
    logic [NCH-1:0] gate_out, pd_en, flt_open, flt_other;

    int    n_tests = 0;
    int    n_fail  = 0;
    string cur_req = "R1";
    bit    done    = 1'b0;

    // behavioural reference state
    bit m_open [NCH];
    bit m_other[NCH];
    bit m_gate [NCH];
    bit m_pd   [NCH];

    always #(CLK_P/2) clk = ~clk;

    lsd_fault_gate #(.NCH(NCH)) dut_i (
        .clk, .rst_n, .drv_rst_n, .gate_sel, .no_pd, .chan_mask, .ol_mask,
        .raw_open, .raw_other, .flt_clr,
        .gate_out, .pd_en, .flt_open, .flt_other
    );

    initial begin
        for (int i = 0; i < NCH; i++) begin
            m_open[i] = 0; m_other[i] = 0; m_gate[i] = 0; m_pd[i] = 1;
        end
    end

    // reference model: updated from sampled inputs on every edge
    always @(posedge clk) begin
        for (int i = 0; i < NCH; i++) begin
            bit eo, et;
            if (!rst_n) begin
                m_open[i] = 0; m_other[i] = 0; m_gate[i] = 0; m_pd[i] = 1;
            end else begin
                eo = raw_open[i] && !chan_mask[i] && !(ol_mask && no_pd[i]);
                et = raw_other[i] && !chan_mask[i];
                if (flt_clr) begin
                    m_open[i] = 0; m_other[i] = 0;
                end else begin
                    m_open[i]  = m_open[i] || eo;
                    m_other[i] = m_other[i] || et;
                end
                m_gate[i] = drv_rst_n && gate_sel[i] && !(m_open[i] || m_other[i]);
                m_pd[i]   = !no_pd[i];
            end
        end
    end

    function automatic logic [NCH-1:0] pack(input bit v[NCH]);
        logic [NCH-1:0] r;
        for (int i = 0; i < NCH; i++) r[i] = v[i];
        return r;
    endfunction

    task automatic check_vec(input string req, input string what,
                             input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(posedge clk) begin
        #(CLK_P/5);
        if (!done) begin
            check_vec(cur_req, "gate_out",  gate_out,  pack(m_gate));
            check_vec(cur_req, "pd_en",     pd_en,     pack(m_pd));
            check_vec(cur_req, "flt_open",  flt_open,  pack(m_open));
            check_vec(cur_req, "flt_other", flt_other, pack(m_other));
        end
    end

    task automatic tick(input int n = 1);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            #(CLK_P*3/10);
        end
    endtask

    initial begin
        #(CLK_P*200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        tick(2);
        check_vec("R1", "gate_out in reset", gate_out, '0);
        check_vec("R1", "pd_en in reset", pd_en, '1);
        rst_n = 1'b1;
        tick();
        check_vec("R1", "flt after release", flt_open | flt_other, '0);

        // R2: gate patterns
        cur_req = "R2";
        gate_sel = 6'h2A; tick();
        check_vec("R2", "gate 2A", gate_out, 6'h2A);
        gate_sel = 6'h15; tick();
        check_vec("R2", "gate 15", gate_out, 6'h15);
        gate_sel = 6'h3F; tick(2);
        check_vec("R2", "gate 3F", gate_out, 6'h3F);

        // R4 R10: other fault on channel 2, single cycle pulse
        cur_req = "R4";
        raw_other = 6'b000100; tick();
        check_vec("R4", "flt_other ch2", flt_other, 6'b000100);
        check_vec("R10", "other gates on", gate_out, 6'b111011);
        raw_other = '0; tick(3);
        cur_req = "R8";
        check_vec("R8", "fault held", flt_other, 6'b000100);

        // R3: driver pin low keeps faults, gates off; return without clear
        cur_req = "R3";
        drv_rst_n = 1'b0; tick();
        check_vec("R3", "gates off", gate_out, '0);
        check_vec("R3", "fault kept", flt_other, 6'b000100);
        drv_rst_n = 1'b1; tick();
        check_vec("R3", "gates back", gate_out, 6'b111011);

        // R8: clear
        cur_req = "R8";
        flt_clr = 1'b1; tick(); flt_clr = 1'b0;
        check_vec("R8", "cleared", flt_other, '0);
        check_vec("R8", "gate after clear", gate_out, 6'h3F);

        // R5: open-load on channel 1
        cur_req = "R5";
        raw_open = 6'b000010; tick();
        check_vec("R5", "open ch1", flt_open, 6'b000010);
        check_vec("R5", "gate ch1 off", gate_out, 6'b111101);
        raw_open = '0; flt_clr = 1'b1; tick(); flt_clr = 1'b0;

        // R6: four combinations of ol_mask and no_pd on channel 3
        cur_req = "R6";
        for (int c = 0; c < 4; c++) begin
            ol_mask = c[1]; no_pd = {2'b0, c[0], 3'b0};
            raw_open = 6'b001000; tick();
            check_vec("R6", "open ch3 combo", flt_open,
                      (c == 3) ? 6'b000000 : 6'b001000);
            raw_open = '0; flt_clr = 1'b1; tick(); flt_clr = 1'b0;
        end
        ol_mask = 1'b0;

        // R9: pull-down enable patterns
        cur_req = "R9";
        no_pd = 6'b101100; tick();
        check_vec("R9", "pd_en", pd_en, 6'b010011);
        no_pd = 6'b010001; tick();
        check_vec("R9", "pd_en", pd_en, 6'b101110);
        no_pd = '0;

        // R7: channel mask hides both fault kinds on channel 4
        cur_req = "R7";
        chan_mask = 6'b010000;
        raw_open = 6'b010000; raw_other = 6'b010000; tick(2);
        check_vec("R7", "no latch masked", flt_open | flt_other, '0);
        check_vec("R7", "gate ch4 stays", gate_out, 6'h3F);
        raw_open = '0; raw_other = '0; chan_mask = '0; tick();

        // R8: clear colliding with a live fault, then relatch
        cur_req = "R8";
        raw_other = 6'b100000; flt_clr = 1'b1; tick();
        flt_clr = 1'b0;
        check_vec("R8", "clear wins", flt_other, '0);
        tick();
        check_vec("R8", "relatch", flt_other, 6'b100000);
        raw_other = '0; tick();

        // R1: reset mid-fault
        cur_req = "R1";
        rst_n = 1'b0; tick();
        check_vec("R1", "reset clears", flt_other, '0);
        rst_n = 1'b1; tick(2);
        check_vec("R1", "gates after reset", gate_out, 6'h3F);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule